// File: doc/BRIEF.md
# Burst Read Responder with Address-Derived Data

This block is the read side of an AXI4 subordinate. It takes one read request at a time on the AR channel and returns every R beat of that burst. For each beat it works out the beat address from the burst type (FIXED, INCR or WRAP), the transfer size and the beat number. The address is then aligned down to a bus word, and the data word is filled one byte lane at a time.

There is no storage behind the block. Each byte is generated as the low eight bits of its own address XORed with a constant parameter. A verification environment can therefore predict every returned byte from the request alone. This makes the block a handy responder for checking bus masters, interconnects and address-generation logic.

Two parameters let a configuration leave out the transfer-size input, the burst-length input, or both. When the size input is left out, every request uses the full bus width. When the length input is left out, every request is a single beat.

Top module: `axi_rd_pattern_slave`

## Requirements
- R1: After reset, ar_ready is 1 and r_valid is 0.
- R2: ar_ready is 0 from the cycle after an AR handshake until the final beat of that burst has been accepted. It is 1 again in the cycle after that acceptance, with r_valid 0.
- R3: r_valid rises in the cycle after the AR handshake. The beat number advances only on a cycle with r_valid and r_ready both 1. While r_ready is 0, r_valid, r_data, r_id and r_last hold their values.
- R4: For ar_burst = 0 (FIXED), every beat uses the request address, aligned down to a bus word.
- R5: For ar_burst = 1 (INCR), beat n uses ar_addr + n * 2^size, aligned down to a bus word. The reserved code 3 behaves as INCR.
- R6: For ar_burst = 2 (WRAP), total = (ar_len + 1) * 2^size, and base is ar_addr aligned down to total. Beat n uses base + ((ar_addr + n * 2^size) mod total), aligned down to a bus word. The legal wrap lengths are ar_len = 1, 3, 7 and 15.
- R7: Bits [8i+7:8i] of r_data carry the byte for address (beat word address + i). That byte equals the low 8 bits of the address XOR the parameter KEY.
- R8: A burst returns exactly ar_len + 1 beats, and r_last is 1 only on beat number ar_len.
- R9: r_id equals the ar_id of the request on every beat, and r_resp is 0 (OKAY).
- R10: With HAS_SIZE = 0, the size is taken as log2 of the bus bytes. With HAS_LEN = 0, the length is taken as 0. The corresponding inputs are ignored.
- R11: An ar_size larger than log2 of the bus bytes is treated as the full bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid | input | 1 | Read request valid |
| ar_ready | output | 1 | Read request accepted when high with ar_valid |
| ar_addr | input | ADDR_W | Request start address |
| ar_id | input | ID_W | Request identifier |
| ar_len | input | 8 | Beats minus one |
| ar_size | input | 3 | log2 of bytes per beat |
| ar_burst | input | 2 | 0 FIXED, 1 INCR, 2 WRAP |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Master accepts the beat |
| r_data | output | DATA_W | Beat data |
| r_id | output | ID_W | Echoed identifier |
| r_resp | output | 2 | Response code, always 0 |
| r_last | output | 1 | Final beat of the burst |

## Verification
The hardest behaviour to reach is a WRAP burst whose start address sits partway into its window, so that the beat sequence folds back to the window base in the middle of the burst. This must also happen while the master is stalling, so that the payload must hold across the fold. The stimulus reaches it with directed wrap bursts at offset starts, followed by random requests. In those requests, wrap lengths come from the legal set, start addresses are random, and r_ready drops about one cycle in four. Every held beat is compared again against the value the bench computes for that beat number. A second instance with the size and length inputs disabled receives a multi-beat, narrow request, and the bench confirms that a single full-width beat comes back.

// File: rtl/axrd_pkg.sv
package axrd_pkg;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'd0,
        BURST_INCR  = 2'd1,
        BURST_WRAP  = 2'd2,
        BURST_RSVD  = 2'd3
    } burst_e;

    // Clamp a requested transfer size to the widest the bus can carry.
    function automatic logic [2:0] clamp_size(input logic [2:0] req, input logic [2:0] widest);
        return (req > widest) ? widest : req;
    endfunction

endpackage

// File: rtl/axrd_beat_addr.sv
module axrd_beat_addr
    import axrd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [2:0]        size,
    input  logic [7:0]        len,
    input  burst_e            burst,
    input  logic [7:0]        beat,
    output logic [ADDR_W-1:0] word_addr
);
    logic [ADDR_W-1:0] step, total, win_mask, linear, raw;

    always_comb begin
        step     = ADDR_W'(beat) << size;
        total    = (ADDR_W'(len) + ADDR_W'(1)) << size;
        win_mask = total - ADDR_W'(1);
        linear   = start_addr + step;
        case (burst)
            BURST_FIXED: raw = start_addr;
            BURST_WRAP:  raw = (start_addr & ~win_mask) | (linear & win_mask);
            default:     raw = linear;
        endcase
        word_addr = {raw[ADDR_W-1:LANE_W], LANE_W'(0)};
    end
endmodule

// File: rtl/axrd_pattern.sv
module axrd_pattern #(
    parameter int         ADDR_W = 32,
    parameter int         BYTES  = 4,
    parameter logic [7:0] KEY    = 8'hA5
) (
    input  logic [ADDR_W-1:0]  word_addr,
    output logic [8*BYTES-1:0] data
);
    logic [7:0] low_byte;
    assign low_byte = word_addr[7:0];

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign data[8*i +: 8] = (low_byte + 8'(i)) ^ KEY;
    end
endmodule

// File: rtl/axrd_ctrl.sv
module axrd_ctrl
    import axrd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ID_W     = 4,
    parameter int LANE_W   = 2,
    parameter bit HAS_SIZE = 1'b1,
    parameter bit HAS_LEN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [7:0]        ar_len,
    input  logic [2:0]        ar_size,
    input  logic [1:0]        ar_burst,
    output logic              r_valid,
    input  logic              r_ready,
    output logic              r_last,
    output logic [ID_W-1:0]   r_id,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [2:0]        cur_size,
    output logic [7:0]        cur_len,
    output burst_e            cur_burst,
    output logic [7:0]        cur_beat
);
    localparam logic [2:0] FULL_SIZE = 3'(LANE_W);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
        logic [7:0]        len;
        logic [2:0]        size;
        burst_e            burst;
    } req_t;

    req_t       req_q, req_d;
    logic       busy_q;
    logic [7:0] beat_q;
    logic [2:0] eff_size;
    logic [7:0] eff_len;
    logic       accept_ar, beat_done, at_final;

    if (HAS_SIZE) begin : g_size
        assign eff_size = clamp_size(ar_size, FULL_SIZE);
    end else begin : g_nosize
        assign eff_size = FULL_SIZE;
    end

    if (HAS_LEN) begin : g_len
        assign eff_len = ar_len;
    end else begin : g_nolen
        assign eff_len = 8'd0;
    end

    always_comb begin
        req_d.addr  = ar_addr;
        req_d.id    = ar_id;
        req_d.len   = eff_len;
        req_d.size  = eff_size;
        req_d.burst = burst_e'(ar_burst);
    end

    assign accept_ar = ar_valid && !busy_q;
    assign beat_done = busy_q && r_ready;
    assign at_final  = (beat_q == req_q.len);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            busy_q <= 1'b0;
            beat_q <= 8'd0;
        end else if (accept_ar) begin
            req_q  <= req_d;
            busy_q <= 1'b1;
            beat_q <= 8'd0;
        end else if (beat_done) begin
            if (at_final) begin
                busy_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 8'd1;
            end
        end
    end

    assign ar_ready  = !busy_q;
    assign r_valid   = busy_q;
    assign r_last    = busy_q && at_final;
    assign r_id      = req_q.id;
    assign cur_addr  = req_q.addr;
    assign cur_size  = req_q.size;
    assign cur_len   = req_q.len;
    assign cur_burst = req_q.burst;
    assign cur_beat  = beat_q;

    // R2
    ar_block_chk: assert property (@(posedge clk) disable iff (rst)
        r_valid |-> !ar_ready);

    // R2
    reopen_chk: assert property (@(posedge clk) disable iff (rst)
        (r_valid && r_ready && r_last) |=> (ar_ready && !r_valid));

    // R3
    first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (ar_valid && ar_ready) |=> (r_valid && r_id == $past(ar_id)));
endmodule

// File: rtl/axi_rd_pattern_slave.sv
module axi_rd_pattern_slave
    import axrd_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter int         DATA_W   = 32,
    parameter int         ID_W     = 4,
    parameter logic [7:0] KEY      = 8'hA5,
    parameter bit         HAS_SIZE = 1'b1,
    parameter bit         HAS_LEN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [7:0]        ar_len,
    input  logic [2:0]        ar_size,
    input  logic [1:0]        ar_burst,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [DATA_W-1:0] r_data,
    output logic [ID_W-1:0]   r_id,
    output logic [1:0]        r_resp,
    output logic              r_last
);
    localparam int BYTES  = DATA_W / 8;
    localparam int LANE_W = $clog2(BYTES);

    logic [ADDR_W-1:0] cur_addr, word_addr;
    logic [2:0]        cur_size;
    logic [7:0]        cur_len, cur_beat;
    burst_e            cur_burst;

    axrd_ctrl #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .LANE_W(LANE_W),
        .HAS_SIZE(HAS_SIZE), .HAS_LEN(HAS_LEN)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .ar_valid(ar_valid), .ar_ready(ar_ready),
        .ar_addr(ar_addr), .ar_id(ar_id), .ar_len(ar_len),
        .ar_size(ar_size), .ar_burst(ar_burst),
        .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last), .r_id(r_id),
        .cur_addr(cur_addr), .cur_size(cur_size), .cur_len(cur_len),
        .cur_burst(cur_burst), .cur_beat(cur_beat)
    );

    axrd_beat_addr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) addr_i (
        .start_addr(cur_addr), .size(cur_size), .len(cur_len),
        .burst(cur_burst), .beat(cur_beat), .word_addr(word_addr)
    );

    axrd_pattern #(.ADDR_W(ADDR_W), .BYTES(BYTES), .KEY(KEY)) pat_i (
        .word_addr(word_addr), .data(r_data)
    );

    assign r_resp = 2'b00;

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_last) && $stable(r_id)));
endmodule

// File: tb/axi_rd_pattern_slave_tb.sv
module axi_rd_pattern_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] KEY_A = 8'hA5;
    localparam logic [7:0] KEY_B = 8'h3C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        ar_valid = 1'b0, ar_ready;
    logic [31:0] ar_addr = '0;
    logic [3:0]  ar_id = '0;
    logic [7:0]  ar_len = '0;
    logic [2:0]  ar_size = '0;
    logic [1:0]  ar_burst = '0;
    logic        r_valid, r_ready = 1'b0, r_last;
    logic [31:0] r_data;
    logic [3:0]  r_id;
    logic [1:0]  r_resp;

    logic        b_ar_valid = 1'b0, b_ar_ready;
    logic        b_r_valid, b_r_ready = 1'b0, b_r_last;
    logic [31:0] b_r_data;
    logic [3:0]  b_r_id;
    logic [1:0]  b_r_resp;

    int errors = 0;
    int checks = 0;

    axi_rd_pattern_slave #(.KEY(KEY_A)) dut_i (
        .clk(clk), .rst(rst), .ar_valid(ar_valid), .ar_ready(ar_ready),
        .ar_addr(ar_addr), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
        .ar_burst(ar_burst), .r_valid(r_valid), .r_ready(r_ready),
        .r_data(r_data), .r_id(r_id), .r_resp(r_resp), .r_last(r_last)
    );

    axi_rd_pattern_slave #(.KEY(KEY_B), .HAS_SIZE(1'b0), .HAS_LEN(1'b0)) dut_nl_i (
        .clk(clk), .rst(rst), .ar_valid(b_ar_valid), .ar_ready(b_ar_ready),
        .ar_addr(ar_addr), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
        .ar_burst(ar_burst), .r_valid(b_r_valid), .r_ready(b_r_ready),
        .r_data(b_r_data), .r_id(b_r_id), .r_resp(b_r_resp), .r_last(b_r_last)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input int sz, input int ln,
                                             input int bt, input int n);
        longint bpb, tot, base, r;
        bpb = longint'(1) << sz;
        tot = bpb * (ln + 1);
        if (bt == 0) r = a;
        else if (bt == 2) begin
            base = longint'(a) - (longint'(a) % tot);
            r = base + ((longint'(a) + n * bpb) % tot);
        end else r = longint'(a) + n * bpb;
        return 32'(r) & ~32'h3;
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] wa, input logic [7:0] key);
        logic [31:0] d;
        for (int i = 0; i < 4; i++) d[8*i +: 8] = 8'((wa + 32'(i)) & 32'hFF) ^ key;
        return d;
    endfunction

    // Issue one request and collect every beat with random back-pressure.
    task automatic run_burst(input logic [31:0] a, input logic [3:0] id, input int ln,
                             input int sz, input int bt);
        int esz, n, guard;
        logic [31:0] ed;
        string tag;
        esz = (sz > 2) ? 2 : sz;
        tag = (bt == 0) ? "R4" : (bt == 2) ? "R6" : "R5";
        @(negedge clk);
        check(ar_ready == 1'b1, "R2 idle before request", 32'(ar_ready), 32'd1);
        ar_valid = 1'b1; ar_addr = a; ar_id = id; ar_len = 8'(ln);
        ar_size = 3'(sz); ar_burst = 2'(bt);
        @(negedge clk);
        ar_valid = 1'b0;
        check(r_valid == 1'b1, "R3 valid after AR", 32'(r_valid), 32'd1);
        check(ar_ready == 1'b0, "R2 blocked while busy", 32'(ar_ready), 32'd0);
        n = 0;
        guard = 0;
        while (n <= ln && guard < 4000) begin
            guard++;
            r_ready = ($urandom_range(3) != 0);
            ed = exp_data(exp_addr(a, esz, ln, bt, n), KEY_A);
            check(r_valid == 1'b1, "R8 beat count", 32'(r_valid), 32'd1);
            check(r_data == ed, {tag, " R7 data"}, r_data, ed);
            check(r_last == (n == ln), "R8 last", 32'(r_last), 32'(n == ln));
            check(r_id == id, "R9 id", 32'(r_id), 32'(id));
            check(r_resp == 2'b00, "R9 resp", 32'(r_resp), 32'd0);
            check(ar_ready == 1'b0, "R2 no new AR", 32'(ar_ready), 32'd0);
            if (r_ready) n++;
            @(negedge clk);
        end
        r_ready = 1'b0;
        check(r_valid == 1'b0, "R8 no extra beat", 32'(r_valid), 32'd0);
        check(ar_ready == 1'b1, "R2 reopen", 32'(ar_ready), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int bt, ln, sz;
        logic [31:0] a;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(ar_ready == 1'b1, "R1 ar_ready after reset", 32'(ar_ready), 32'd1);
        check(r_valid == 1'b0, "R1 r_valid after reset", 32'(r_valid), 32'd0);

        run_burst(32'h0000_1003, 4'h3, 3, 0, 0);    // R4 fixed, unaligned
        run_burst(32'h0000_0040, 4'h1, 0, 2, 1);    // R5 single beat
        run_burst(32'h0000_0FF0, 4'h7, 255, 2, 1);  // R5 longest INCR
        run_burst(32'h0000_0102, 4'h2, 9, 1, 3);    // R5 reserved code acts as INCR
        run_burst(32'h0000_1008, 4'h9, 3, 2, 2);    // R6 wraps mid-burst
        run_burst(32'h0000_2007, 4'hA, 15, 0, 2);   // R6 byte wrap
        run_burst(32'h0000_301C, 4'hB, 7, 2, 2);    // R6 starts at window top
        run_burst(32'h0000_0010, 4'hC, 2, 3, 1);    // R11 oversized ar_size

        for (int k = 0; k < 60; k++) begin
            bt = $urandom_range(2);
            sz = $urandom_range(2);
            a  = $urandom;
            if (bt == 2) ln = (2 << $urandom_range(3)) - 1;
            else if (bt == 0) ln = $urandom_range(15);
            else ln = ($urandom_range(9) == 0) ? 255 : $urandom_range(40);
            run_burst(a, 4'($urandom), ln, sz, bt);
        end

        // R10: size and length inputs ignored on the second instance
        @(negedge clk);
        ar_addr = 32'h0000_0033; ar_len = 8'd5; ar_size = 3'd0; ar_burst = 2'd1; ar_id = 4'h6;
        b_ar_valid = 1'b1;
        b_r_ready = 1'b1;
        @(negedge clk);
        b_ar_valid = 1'b0;
        check(b_r_valid == 1'b1, "R10 beat present", 32'(b_r_valid), 32'd1);
        check(b_r_last == 1'b1, "R10 single beat", 32'(b_r_last), 32'd1);
        check(b_r_data == exp_data(32'h30, KEY_B), "R10 full-width data",
              b_r_data, exp_data(32'h30, KEY_B));
        check(b_r_id == 4'h6, "R10 id", 32'(b_r_id), 32'h6);
        @(negedge clk);
        check(b_r_valid == 1'b0, "R10 no second beat", 32'(b_r_valid), 32'd0);
        check(b_ar_ready == 1'b1, "R10 reopen", 32'(b_ar_ready), 32'd1);
        b_r_ready = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule